// File: doc/BRIEF.md
# Write Header Serializer

This block opens every write burst with a fixed header and then hands the serial write line over to user data. While the write gate is held high, it advances one bit for each clock cycle in which the bit-clock enable is high. It first sends two identical run-length address marks back to back, then a short preamble built from 3T groups. Once the last preamble bit has left, the serial output copies the NRZ write-data input, again one bit per enable.

The host must hold the NRZ input at zero for as long as the header is being sent. The block watches that input during the header window and raises a sticky error flag if it sees a one there. When the write gate drops, at any point and on any clock, the burst ends: the output returns to zero, both flags clear, and the next rise of the gate starts the header again from its first bit. The run-length encoder upstream and the write driver downstream are outside this block.

Each address mark is 39 bits long. It carries a one at offsets 7, 15 and 27 and zeros everywhere else; in run-length terms that is 7 zeros, a one, 7 zeros, a one, 11 zeros, a one, then 11 zeros. The preamble is three groups of `1,0,0`. The whole header is therefore 87 bits.

States of the sequencer and how it moves between them:
- `ST_IDLE`: the gate is low or the burst has not started. On the first enable with the gate high, the sequencer sends mark bit 0 and moves to `ST_MARK_A`.
- `ST_MARK_A`: sends the first mark. After offset 38 it moves to `ST_MARK_B`.
- `ST_MARK_B`: sends the second mark. After offset 38 it moves to `ST_PRE`.
- `ST_PRE`: sends the preamble. After bit 8 it moves to `ST_PASS`.
- `ST_PASS`: copies the NRZ input to the serial output.
- From any state, a low write gate returns the sequencer to `ST_IDLE`.

Top module: `wrhdr_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with the gate low, `ser_out`, `hdr_done` and `hdr_err` are all 0.
- R2: A tick is a clock edge at which both `wr_gate` and `bit_en` are high. Tick 0 is the first tick after the gate rises. After each tick k, for k from 0 to 77, `ser_out` shows address-mark bit (k mod 39). That bit is 1 at offsets 7, 15 and 27 and 0 at every other offset.
- R3: After ticks 78 to 86, `ser_out` shows the preamble. It is 1 after ticks 78, 81 and 84 and 0 after the other six.
- R4: After any tick numbered 87 or higher, `ser_out` equals the value `nrz_in` had at that tick.
- R5: `hdr_done` is high for exactly one clock cycle, the cycle right after tick 86. It is low in every other cycle.
- R6: `hdr_err` becomes 1 after any tick from 0 to 86 at which `nrz_in` is 1. It then stays 1 while the gate stays high. A 1 on `nrz_in` at tick 87 or later, or in a cycle that is not a tick, does not set it.
- R7: A clock edge with `wr_gate` low clears `ser_out`, `hdr_done` and `hdr_err` to 0 and restarts the header count, so the next tick is tick 0 again.
- R8: A clock edge with `wr_gate` high and `bit_en` low leaves `ser_out`, `hdr_err` and the header position unchanged, and drives `hdr_done` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable; one bit moves per high cycle |
| wr_gate | input | 1 | Write gate; high for the length of a burst |
| nrz_in | input | 1 | NRZ write data from the host |
| ser_out | output | 1 | Serial write output |
| hdr_done | output | 1 | One-cycle pulse after the final preamble bit is sent |
| hdr_err | output | 1 | Sticky flag: non-zero NRZ input seen during the header |

## Verification
Two events can meet on tick 86, the final header tick: the `hdr_done` pulse and a late setting of `hdr_err`. The bench drives `nrz_in` high on exactly that tick and expects both outputs to rise on the same edge. It also drives a one on tick 87, which must pass through to `ser_out` without touching the error flag. A second collision drops the gate on the edge where tick 86 would have happened; the clear must win, so neither flag rises and `ser_out` returns to zero.

// File: rtl/wrhdr_pkg.sv
package wrhdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK_A,
        ST_MARK_B,
        ST_PRE,
        ST_PASS
    } wr_state_e;

endpackage

// File: rtl/wrhdr_pattern.sv
module wrhdr_pattern
    import wrhdr_pkg::*;
#(
    parameter int RUN_SHORT = 7,
    parameter int RUN_LONG  = 11,
    parameter int GROUP_LEN = 3,
    parameter int IDX_W     = 6
) (
    input  wr_state_e        seg,
    input  logic [IDX_W-1:0] idx,
    output logic             pat_bit
);

    // positions of the three ones inside a mark
    localparam int ONE_A = RUN_SHORT;
    localparam int ONE_B = 2 * RUN_SHORT + 1;
    localparam int ONE_C = 2 * RUN_SHORT + RUN_LONG + 2;

    always_comb begin
        unique case (seg)
            ST_MARK_A, ST_MARK_B: begin
                pat_bit = (int'(idx) == ONE_A) || (int'(idx) == ONE_B) ||
                          (int'(idx) == ONE_C);
            end
            ST_PRE: begin
                pat_bit = ((int'(idx) % GROUP_LEN) == 0);
            end
            default: begin
                pat_bit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wrhdr_fsm.sv
module wrhdr_fsm
    import wrhdr_pkg::*;
#(
    parameter int MARK_LEN = 39,
    parameter int PRE_LEN  = 9,
    parameter int IDX_W    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             wr_gate,
    output wr_state_e        emit_seg,
    output logic [IDX_W-1:0] emit_idx,
    output logic             tick,
    output logic             in_hdr,
    output logic             last_hdr
);

    wr_state_e        state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;
    int               seg_len;
    logic             seg_end;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // the idle state sends mark bit 0 on its first tick
    always_comb begin
        tick     = bit_en && wr_gate;
        emit_seg = (state_q == ST_IDLE) ? ST_MARK_A : state_q;
        emit_idx = (state_q == ST_IDLE) ? '0 : cnt_q;
        unique case (emit_seg)
            ST_MARK_A, ST_MARK_B: seg_len = MARK_LEN;
            ST_PRE:               seg_len = PRE_LEN;
            default:              seg_len = 1;
        endcase
        seg_end  = (int'(emit_idx) == seg_len - 1);
        in_hdr   = (emit_seg != ST_PASS);
        last_hdr = tick && (emit_seg == ST_PRE) && seg_end;
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!wr_gate) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (emit_seg)
                ST_MARK_A: begin
                    state_d = seg_end ? ST_MARK_B : ST_MARK_A;
                    cnt_d   = seg_end ? '0 : emit_idx + 1'b1;
                end
                ST_MARK_B: begin
                    state_d = seg_end ? ST_PRE : ST_MARK_B;
                    cnt_d   = seg_end ? '0 : emit_idx + 1'b1;
                end
                ST_PRE: begin
                    state_d = seg_end ? ST_PASS : ST_PRE;
                    cnt_d   = seg_end ? '0 : emit_idx + 1'b1;
                end
                ST_PASS: begin
                    state_d = ST_PASS;
                    cnt_d   = '0;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/wrhdr_outreg.sv
module wrhdr_outreg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_gate,
    input  logic tick,
    input  logic in_hdr,
    input  logic last_hdr,
    input  logic pat_bit,
    input  logic nrz_in,
    output logic ser_out,
    output logic hdr_done,
    output logic hdr_err
);

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_out  <= 1'b0;
            hdr_done <= 1'b0;
            hdr_err  <= 1'b0;
        end else if (!wr_gate) begin
            ser_out  <= 1'b0;
            hdr_done <= 1'b0;
            hdr_err  <= 1'b0;
        end else if (tick) begin
            ser_out  <= in_hdr ? pat_bit : nrz_in;
            hdr_done <= last_hdr;
            hdr_err  <= hdr_err | (in_hdr & nrz_in);
        end else begin
            hdr_done <= 1'b0;
        end
    end

endmodule

// File: rtl/wrhdr_gen.sv
module wrhdr_gen
    import wrhdr_pkg::*;
#(
    parameter int RUN_SHORT = 7,
    parameter int RUN_LONG  = 11,
    parameter int GROUP_LEN = 3,
    parameter int GROUP_CNT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic wr_gate,
    input  logic nrz_in,
    output logic ser_out,
    output logic hdr_done,
    output logic hdr_err
);

    localparam int MARK_LEN = 2 * RUN_SHORT + 2 * RUN_LONG + 3;
    localparam int PRE_LEN  = GROUP_LEN * GROUP_CNT;
    localparam int MAX_LEN  = (MARK_LEN > PRE_LEN) ? MARK_LEN : PRE_LEN;
    localparam int IDX_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    wr_state_e        emit_seg;
    logic [IDX_W-1:0] emit_idx;
    logic             tick;
    logic             in_hdr;
    logic             last_hdr;
    logic             pat_bit;

    wrhdr_fsm #(
        .MARK_LEN (MARK_LEN),
        .PRE_LEN  (PRE_LEN),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .wr_gate  (wr_gate),
        .emit_seg (emit_seg),
        .emit_idx (emit_idx),
        .tick     (tick),
        .in_hdr   (in_hdr),
        .last_hdr (last_hdr)
    );

    wrhdr_pattern #(
        .RUN_SHORT (RUN_SHORT),
        .RUN_LONG  (RUN_LONG),
        .GROUP_LEN (GROUP_LEN),
        .IDX_W     (IDX_W)
    ) u_pat (
        .seg     (emit_seg),
        .idx     (emit_idx),
        .pat_bit (pat_bit)
    );

    wrhdr_outreg u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_gate  (wr_gate),
        .tick     (tick),
        .in_hdr   (in_hdr),
        .last_hdr (last_hdr),
        .pat_bit  (pat_bit),
        .nrz_in   (nrz_in),
        .ser_out  (ser_out),
        .hdr_done (hdr_done),
        .hdr_err  (hdr_err)
    );

endmodule

// File: rtl/wrhdr_chk.sv
module wrhdr_chk #(
    parameter int HDR_LEN = 87
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic wr_gate,
    input logic nrz_in,
    input logic ser_out,
    input logic hdr_done,
    input logic hdr_err
);

    // ticks seen since the gate rose, saturating past the header
    int tk;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tk <= 0;
        else if (!wr_gate)
            tk <= 0;
        else if (bit_en && tk <= HDR_LEN)
            tk <= tk + 1;
    end

    // R7: a low gate clears every output
    a_r7_gate_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_gate |=> (!ser_out && !hdr_done && !hdr_err));

    // R5: done lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> !hdr_done);

    // R5: done only after the final header tick
    a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> (tk == HDR_LEN));

    // R6: error stays while the gate stays high
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_err && wr_gate) |=> hdr_err);

    // R6: data after the header never raises the error
    a_r6_err_header_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate && !hdr_err && tk >= HDR_LEN) |=> !hdr_err);

    // R8: no enable, no movement
    a_r8_hold_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate && !bit_en) |=> ($stable(ser_out) && !hdr_done));

    // R4: pass-through after the header
    a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate && bit_en && tk >= HDR_LEN) |=> (ser_out == $past(nrz_in)));

endmodule

bind wrhdr_gen wrhdr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .wr_gate  (wr_gate),
    .nrz_in   (nrz_in),
    .ser_out  (ser_out),
    .hdr_done (hdr_done),
    .hdr_err  (hdr_err)
);

// File: tb/sim_wrhdr_gen.sv
module sim_wrhdr_gen;

    localparam int CLK_PERIOD = 10;
    localparam int HDR_TICKS  = 87;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic wr_gate = 1'b0;
    logic nrz_in = 1'b0;
    logic ser_out, hdr_done, hdr_err;

    int checks = 0;
    int errors = 0;

    // reference model state
    int    mk = 0;
    bit    m_ser = 0, m_done = 0, m_err = 0;
    string ser_tag = "R1";

    always #(CLK_PERIOD / 2) clk = ~clk;

    wrhdr_gen u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .wr_gate  (wr_gate),
        .nrz_in   (nrz_in),
        .ser_out  (ser_out),
        .hdr_done (hdr_done),
        .hdr_err  (hdr_err)
    );

    // header bit k as given by R2 and R3
    function automatic bit hdr_ref(input int k);
        int m;
        if (k < 78) begin
            m = k % 39;
            return (m == 7) || (m == 15) || (m == 27);
        end
        return ((k - 78) % 3) == 0;
    endfunction

    task automatic chk(input bit act, input bit exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at tick %0d (t=%0t)",
                     req, what, act, exp, mk, $time);
        end
    endtask

    task automatic model_step(input bit g, input bit e, input bit d);
        if (!g) begin
            mk = 0; m_ser = 0; m_done = 0; m_err = 0;
            ser_tag = "R7";
        end else if (e) begin
            if (mk < HDR_TICKS) begin
                m_ser   = hdr_ref(mk);
                m_err   = m_err | d;
                m_done  = (mk == HDR_TICKS - 1);
                ser_tag = (mk < 78) ? "R2" : "R3";
                mk++;
            end else begin
                m_ser   = d;
                m_done  = 0;
                ser_tag = "R4";
            end
        end else begin
            m_done  = 0;
            ser_tag = "R8";
        end
    endtask

    task automatic cyc(input bit g, input bit e, input bit d);
        @(negedge clk);
        wr_gate = g; bit_en = e; nrz_in = d;
        model_step(g, e, d);
        @(posedge clk);
        #1;
        chk(ser_out, m_ser, ser_tag, "ser_out");
        chk(hdr_done, m_done, "R5", "hdr_done");
        chk(hdr_err, m_err, g ? "R6" : "R7", "hdr_err");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int len;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(ser_out, 0, "R1", "ser_out in reset");
        chk(hdr_done, 0, "R1", "hdr_done in reset");
        chk(hdr_err, 0, "R1", "hdr_err in reset");
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 1, 1);

        // R2 R3 R4: full burst, enable every cycle, random data after header
        for (int i = 0; i < HDR_TICKS + 25; i++)
            cyc(1, 1, (mk >= HDR_TICKS) ? 1'($urandom_range(0, 1)) : 1'b0);
        cyc(0, 0, 0);

        // R5 R6: error on the last header tick meets done; tick 87 data is a one
        for (int i = 0; i < HDR_TICKS + 5; i++)
            cyc(1, 1, (mk >= HDR_TICKS - 1) ? 1'b1 : 1'b0);
        cyc(0, 1, 0);

        // R6: one after the header only must not set the flag
        for (int i = 0; i < HDR_TICKS + 6; i++)
            cyc(1, 1, (mk >= HDR_TICKS) ? 1'b1 : 1'b0);
        cyc(0, 1, 0);

        // R6: error on tick 0, then held with no enables (R8)
        cyc(1, 1, 1);
        for (int i = 0; i < 5; i++) cyc(1, 0, 1);
        for (int i = 0; i < 10; i++) cyc(1, 1, 0);
        cyc(0, 1, 0);

        // R7: abort at the edge where tick 86 would fall, then restart
        while (mk < HDR_TICKS - 1) cyc(1, 1, 0);
        cyc(0, 1, 1);
        cyc(0, 1, 0);
        for (int i = 0; i < 20; i++) cyc(1, 1, 0);
        cyc(0, 0, 0);

        // random bursts with sparse enables and rare header errors
        for (int r = 0; r < 40; r++) begin
            len = $urandom_range(1, 200);
            for (int i = 0; i < len; i++) begin
                bit e, d;
                e = ($urandom_range(0, 9) < 6);
                if (mk < HDR_TICKS) d = ($urandom_range(0, 59) == 0);
                else                d = 1'($urandom_range(0, 1));
                cyc(1, e, d);
            end
            cyc(0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule